// File: doc/BRIEF.md
# Two-Phase Wired-OR Wakeup Arbiter

This block picks the highest-priority requester among a set of I/O controllers that share only three wake lines. Each controller holds a 4-bit task number, and a larger number means higher priority. A sequence starts with a one-cycle sync pulse from the processor. In the cycle after the pulse (phase 1), every controller that latched a request drives a code for the upper two bits of its task number. At the end of phase 1, every controller compares the OR of the lines with its own upper bits, and any controller that has been outbid stops. In phase 2, the controllers still in the contest drive a code for their lower two bits. Phase 2 lasts until the next sync pulse, so it grows longer when the processor stalls.

The processor-side decoder turns the OR of the lines into two bits in each phase. It joins the two halves into the winning task number. It reports the result with a one-cycle valid flag after the pulse that closes phase 2. The top module contains a parameterised number of controller agents, the OR of their line outputs, and the decoder. Lines are modelled active-high. Each agent receives its task number as an input, because the number is assigned at run time.

Top module: `wake_arb`

## Requirements
- R1: Encoding of a 2-bit group onto the lines (bit 0 is line 1, bit 1 is line 2, bit 2 is line 3): 00 drives nothing, 01 drives line 1 only, 10 drives line 2 only, 11 drives line 3 only. `wake_lines` is the OR of all agents' drives.
- R2: The decoder forms a group from the lines as msb = line2 OR line3 and lsb = line3 OR (line1 AND NOT line2). The same rule is used in both phases.
- R3: In the cycle after a sync pulse, the lines carry the OR of the R1 codes of the upper two task bits of every agent whose request was high at that pulse.
- R4: From the second cycle after the pulse, the only agents that drive the lines are those whose upper bits equal the highest upper group seen in phase 1. Each of them drives the R1 code of its lower two task bits.
- R5: The sync pulse that closes phase 2 is followed one cycle later by `win_valid` high, with `win_task` equal to the largest task number among the requesters.
- R6: Phase 2 extends over any number of cycles until the next sync pulse, and the lines hold their phase-2 value throughout, including the closing pulse cycle.
- R7: Requests and task numbers are captured only at the sync pulse. Changes to them during a sequence have no effect on that sequence.
- R8: If no agent requests, or if only agents with task number 0 request, `win_valid` stays low and `win_task` keeps its previous value.
- R9: After reset, and until the first sync pulse, the lines are idle, `win_valid` is low and `win_task` is 0.
- R10: `win_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pulse | input | 1 | One-cycle sequence start; also closes the previous phase 2 |
| req | input | NUM_AGENTS | Per-agent wakeup request |
| task_ids | input | 4*NUM_AGENTS | Per-agent task number, agent k in bits [4k+3:4k] |
| wake_lines | output | 3 | OR of all agents' line drives |
| win_valid | output | 1 | One-cycle flag that a winner is reported |
| win_task | output | 4 | Winning task number |

## Verification
The hardest situation to reach is a tie in the upper group while the lower groups differ. In that case several agents survive phase 1, and their phase-2 codes overlap on the lines during a stretched phase 2. The bench sweeps every request pattern over 64 distinct task-number assignments built from an odd-stride rotation, so collisions in the upper group occur in many combinations. It inserts a varying number of stall cycles before each closing pulse. During the stall cycles it inverts the requests and scrambles the task-number inputs, which checks that mid-sequence changes are ignored.

// File: rtl/wk_pkg.sv
// Shared definitions for the two-phase wakeup arbiter: phase type and the
// group-to-line code with its inverse. Assumes three active-high lines.
package wk_pkg;

    localparam int GRP_W  = 2;
    localparam int LINE_W = 3;
    localparam int TASK_W = 2 * GRP_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2
    } wk_phase_e;

    // Map a 2-bit group onto at most one line.
    function automatic logic [LINE_W-1:0] wk_encode(input logic [GRP_W-1:0] grp);
        logic [LINE_W-1:0] code;
        case (grp)
            2'b01:   code = 3'b001;
            2'b10:   code = 3'b010;
            2'b11:   code = 3'b100;
            default: code = 3'b000;
        endcase
        return code;
    endfunction

    // Recover the highest group from the OR of several codes.
    function automatic logic [GRP_W-1:0] wk_decode(input logic [LINE_W-1:0] lines);
        logic [GRP_W-1:0] grp;
        grp[1] = lines[1] | lines[2];
        grp[0] = lines[2] | (lines[0] & ~lines[1]);
        return grp;
    endfunction

endpackage

// File: rtl/wk_phase_seq.sv
// Phase tracker: follows the sync pulse to tell phase 1 (cycle after the
// pulse) from phase 2 (all later cycles up to and including the next pulse).
// Assumes the pulse is one cycle wide.
module wk_phase_seq
    import wk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_pulse,
    output wk_phase_e phase
);

    // Advance the phase on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (sync_pulse) begin
            phase <= PH_ONE;
        end else if (phase == PH_ONE) begin
            phase <= PH_TWO;
        end
    end

endmodule

// File: rtl/wk_agent.sv
// Controller-side agent: captures request and task number at the sync pulse,
// drives the upper-group code in phase 1, withdraws if outbid, and drives the
// lower-group code through all of phase 2. Assumes bus_lines is the OR of all
// agents' drives, which depend on registers only.
module wk_agent
    import wk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pulse,
    input  logic              req,
    input  logic [TASK_W-1:0] task_id,
    input  logic [LINE_W-1:0] bus_lines,
    output logic [LINE_W-1:0] drive
);

    wk_phase_e         phase;
    logic              req_q;
    logic              stay_q;
    logic [TASK_W-1:0] id_q;

    wk_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .phase      (phase)
    );

    // Capture request and task number only at the sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            id_q  <= '0;
        end else if (sync_pulse) begin
            req_q <= req;
            id_q  <= task_id;
        end
    end

    // Decide at the end of phase 1 whether to stay for phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_pulse) begin
            stay_q <= 1'b0;
        end else if (phase == PH_ONE) begin
            stay_q <= req_q && (wk_decode(bus_lines) <= id_q[TASK_W-1:GRP_W]);
        end
    end

    // Select the code to place on the lines for the current phase.
    always_comb begin
        drive = '0;
        if (phase == PH_ONE && req_q) begin
            drive = wk_encode(id_q[TASK_W-1:GRP_W]);
        end else if (phase == PH_TWO && stay_q) begin
            drive = wk_encode(id_q[GRP_W-1:0]);
        end
    end

endmodule

// File: rtl/wk_decoder.sv
// Processor-side decoder: saves the upper group at the end of phase 1 and
// joins it with the lower group sampled at the pulse that closes phase 2.
// Assumes lines hold their phase-2 value up to that pulse.
module wk_decoder
    import wk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pulse,
    input  logic [LINE_W-1:0] bus_lines,
    output logic              win_valid,
    output logic [TASK_W-1:0] win_task,
    output wk_phase_e         phase
);

    logic [GRP_W-1:0] hi_q;
    logic             seen_q;
    logic             close_now;

    wk_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .phase      (phase)
    );

    // A sequence completes at a pulse that arrives during phase 2.
    assign close_now = sync_pulse && (phase == PH_TWO);

    // Save the upper group and whether any line was active in phase 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            seen_q <= 1'b0;
        end else if (phase == PH_ONE && !sync_pulse) begin
            hi_q   <= wk_decode(bus_lines);
            seen_q <= |bus_lines;
        end
    end

    // Report the winner for one cycle after the closing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_task  <= '0;
        end else begin
            win_valid <= close_now && (seen_q || (|bus_lines));
            if (close_now && (seen_q || (|bus_lines))) begin
                win_task <= {hi_q, wk_decode(bus_lines)};
            end
        end
    end

endmodule

// File: rtl/wake_arb.sv
// Top: a row of controller agents sharing three wired-OR lines, plus the
// processor-side decoder. Assumes task numbers stay put between pulses only
// as far as the agents capture them at each pulse.
module wake_arb
    import wk_pkg::*;
#(
    parameter int NUM_AGENTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sync_pulse,
    input  logic [NUM_AGENTS-1:0]        req,
    input  logic [TASK_W*NUM_AGENTS-1:0] task_ids,
    output logic [LINE_W-1:0]            wake_lines,
    output logic                         win_valid,
    output logic [TASK_W-1:0]            win_task
);

    logic [LINE_W-1:0] drives [NUM_AGENTS];
    wk_phase_e         dec_phase;

    for (genvar k = 0; k < NUM_AGENTS; k++) begin : g_agent
        wk_agent u_agent (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_pulse (sync_pulse),
            .req        (req[k]),
            .task_id    (task_ids[k*TASK_W +: TASK_W]),
            .bus_lines  (wake_lines),
            .drive      (drives[k])
        );
    end

    // Model the wired-OR of all agent drives.
    always_comb begin
        wake_lines = '0;
        for (int k = 0; k < NUM_AGENTS; k++) begin
            wake_lines = wake_lines | drives[k];
        end
    end

    wk_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .bus_lines  (wake_lines),
        .win_valid  (win_valid),
        .win_task   (win_task),
        .phase      (dec_phase)
    );

endmodule

// File: rtl/wake_arb_chk.sv
// Assertion checker for wake_arb, bound to every instance of the top.
module wake_arb_chk
    import wk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sync_pulse,
    input logic [LINE_W-1:0] wake_lines,
    input logic              win_valid,
    input logic [TASK_W-1:0] win_task,
    input wk_phase_e         phase
);

    // R9
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (wake_lines == 3'b000));

    // R6
    ph2_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TWO && $past(phase) == PH_TWO) |-> $stable(wake_lines));

    // R5
    valid_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ($past(sync_pulse) && $past(phase) == PH_TWO));

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);

    // R8
    nonzero_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_task != 4'd0));

endmodule

bind wake_arb wake_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (sync_pulse),
    .wake_lines (wake_lines),
    .win_valid  (win_valid),
    .win_task   (win_task),
    .phase      (dec_phase)
);

// File: tb/wake_arb_tb_top.sv
`timescale 1ns/1ps
// Sweep of request patterns, task-number rotations and stall lengths for
// wake_arb with four agents; expected line codes and winners are computed here.
module wake_arb_tb_top;

    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_pulse = 1'b0;
    logic [N-1:0]  req = '0;
    logic [4*N-1:0] task_ids = '0;
    logic [2:0]    wake_lines;
    logic          win_valid;
    logic [3:0]    win_task;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    wake_arb #(.NUM_AGENTS(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .req        (req),
        .task_ids   (task_ids),
        .wake_lines (wake_lines),
        .win_valid  (win_valid),
        .win_task   (win_task)
    );

    always #2 clk = ~clk;

    // Line code of a 2-bit group (R1).
    function automatic logic [2:0] code_of(input int g);
        return (g == 0) ? 3'b000 : 3'(1 << (g - 1));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int   ids [N];
        int   maxt, ph1, ph2, hi;
        int   prev_ph2, prev_max, last_win;
        bit   have_prev;
        int   steps [4];
        steps = '{1, 3, 5, 7};
        have_prev = 0;
        prev_ph2 = 0;
        prev_max = 0;
        last_win = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9 lines in reset", int'(wake_lines), 0);
        chk("R9 valid in reset", int'(win_valid), 0);
        chk("R9 task in reset", int'(win_task), 0);
        rst_n = 1'b1;
        req = '1;
        task_ids = 16'hFEDC;
        repeat (4) begin
            @(negedge clk);
            // R9: no sync yet, nothing driven
            chk("R9 lines before first sync", int'(wake_lines), 0);
            chk("R9 valid before first sync", int'(win_valid), 0);
        end

        for (int s = 0; s < 4; s++) begin
            for (int base = 0; base < 16; base++) begin
                for (int pat = 0; pat < 16; pat++) begin
                    int stall;
                    stall = (base + pat) % 4;
                    maxt = -1;
                    ph1 = 0;
                    for (int k = 0; k < N; k++) begin
                        ids[k] = (base + k * steps[s]) % 16;
                        task_ids[4*k +: 4] = 4'(ids[k]);
                        if (pat[k]) begin
                            if (ids[k] > maxt) maxt = ids[k];
                            ph1 = ph1 | int'(code_of(ids[k] / 4));
                        end
                    end
                    hi = (maxt < 0) ? 0 : maxt / 4;
                    ph2 = 0;
                    for (int k = 0; k < N; k++) begin
                        if (pat[k] && (ids[k] / 4) == hi)
                            ph2 = ph2 | int'(code_of(ids[k] % 4));
                    end

                    // Pulse cycle: still phase 2 of the previous round.
                    if (have_prev) begin
                        // R6: lines held through the closing pulse
                        chk("R6 lines at closing pulse", int'(wake_lines), prev_ph2);
                    end
                    req = 4'(pat);
                    sync_pulse = 1'b1;

                    @(negedge clk);
                    sync_pulse = 1'b0;
                    if (have_prev) begin
                        if (prev_max > 0) begin
                            // R5: winner reported after the closing pulse
                            chk("R5 valid", int'(win_valid), 1);
                            chk("R5 winner", int'(win_task), prev_max);
                            last_win = prev_max;
                        end else begin
                            // R8: no visible requester
                            chk("R8 valid low", int'(win_valid), 0);
                            chk("R8 task held", int'(win_task), last_win);
                        end
                    end
                    // R1 R2 R3: phase-1 upper-group codes
                    chk("R3 phase-1 lines", int'(wake_lines), ph1);
                    // R7: change inputs mid-sequence
                    req = ~4'(pat);
                    task_ids = ~task_ids;

                    @(negedge clk);
                    // R4: only top-group survivors drive lower codes
                    chk("R4 phase-2 lines", int'(wake_lines), ph2);
                    // R10: valid was a single-cycle pulse
                    chk("R10 valid dropped", int'(win_valid), 0);

                    for (int t = 0; t < stall; t++) begin
                        @(negedge clk);
                        // R6 R7: extended phase 2 unchanged
                        chk("R6 R7 stalled phase-2 lines", int'(wake_lines), ph2);
                    end

                    have_prev = 1;
                    prev_ph2 = ph2;
                    prev_max = maxt;
                end
            end
        end

        // Close the last round with no requests.
        req = '0;
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        if (prev_max > 0) begin
            chk("R5 final valid", int'(win_valid), 1);
            chk("R5 final winner", int'(win_task), prev_max);
            last_win = prev_max;
        end else begin
            chk("R8 final valid low", int'(win_valid), 0);
        end
        @(negedge clk);
        @(negedge clk);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        // R8: empty round gives no flag and keeps the winner
        chk("R8 empty round valid", int'(win_valid), 0);
        chk("R8 empty round task", int'(win_task), last_win);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule